// File: doc/BRIEF.md
# Token-Chain Population Counter

This block counts the set bits of an input word by sending a one-hot token through a linear chain of small shift-switch cells. Each cell is configured by one bit of the accepted word. A cell configured with 0 passes the token through without change. A cell configured with 1 moves the token up by one position. When the token leaves the top position, the cell raises a rotation flag and the token re-enters at the bottom, so the token position holds the count modulo the token width. A tally stage adds the token width times the number of rotation flags to the final token position, which gives the full count.

Configuring the chain is modelled as the acceptance of a word on the input stream. The chain settles within the same cycle as that acceptance. The result is registered and offered on an output stream in the next cycle.

Both edges use valid/ready. An input word is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in that same cycle. While a result is held and `out_ready` is low, the block stalls: it accepts nothing and keeps the held count unchanged.

Top module: `ones_chain_counter`

## Requirements
- R1: After reset, `out_valid` is 0, `count` is 0 and `in_ready` is 1.
- R2: When a word is accepted at a clock edge, `out_valid` is 1 after that edge and `count` equals the number of 1 bits in the accepted word.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and at the next edge `out_valid` stays 1 with `count` unchanged.
- R4: A word offered with `in_valid` high while `in_ready` is low is ignored: the held `count` does not change.
- R5: If a result is consumed and a new word is accepted at the same edge, `out_valid` stays 1 and `count` becomes the popcount of the new word, with no idle cycle in between.
- R6: If a result is consumed and no word is accepted at that edge, `out_valid` is 0 after the edge.
- R7: The count covers its whole range, from 0 for an all-zero word to N (16 by default) for an all-ones word, and `count` never exceeds N while valid.
- R8: The count is correct for every pattern of set bits. This includes runs long enough that the token wraps several times, which shows that the rotation feedback and the rotation tally agree for all 2^16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_vec | input | N | Word whose bits configure the cells |
| out_valid | output | 1 | `count` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| count | output | $clog2(N+1) | Number of 1 bits in the last accepted word |

## Verification
The two functions that can coincide are draining the held result and accepting a new word at the same edge. The bench holds `in_valid` and `out_ready` high together for a sweep over every 16-bit word, so each edge both hands off a count and loads a new one. Each cycle's count is compared with the popcount of the word offered one cycle earlier. The opposite case is also driven: a word is offered while the consumer stalls, and the bench checks that the held count survives unchanged and that the offered word is never taken.

// File: rtl/ones_chain_pkg.sv
package ones_chain_pkg;
  // default geometry of the counting chain
  localparam int unsigned DEF_CELLS = 16;
  localparam int unsigned DEF_TOKEN = 3;

  // bit index of the set bit in a one-hot word (0 when none set)
  function automatic int unsigned hot_index(input logic [31:0] word, input int unsigned width);
    int unsigned idx;
    idx = 0;
    for (int unsigned b = 0; b < width; b++) begin
      if (word[b]) idx = b;
    end
    return idx;
  endfunction
endpackage

// File: rtl/ss_cell.sv
module ss_cell #(
  parameter int unsigned TOK_W = 3
) (
  input  logic             cfg,
  input  logic [TOK_W-1:0] tok_in,
  input  logic             wrap_in,
  output logic [TOK_W-1:0] tok_out,
  output logic             rot_out
);
  // pass straight when cfg is 0, step up one position when cfg is 1
  always_comb begin
    if (cfg) tok_out = {tok_in[TOK_W-2:0], wrap_in};
    else     tok_out = tok_in;
  end

  assign rot_out = cfg & tok_in[TOK_W-1];
endmodule

// File: rtl/ss_chain.sv
module ss_chain #(
  parameter int unsigned N     = 16,
  parameter int unsigned TOK_W = 3
) (
  input  logic [N-1:0]     cfg,
  output logic [TOK_W-1:0] tok_final,
  output logic [N-1:0]     rot
);
  localparam logic [TOK_W-1:0] SEED = TOK_W'(1);

  logic [TOK_W-1:0] link [N+1];

  assign link[0] = SEED;

  for (genvar i = 0; i < N; i++) begin : g_cell
    // the rotation bit of each cell re-enters its own bottom position
    ss_cell #(.TOK_W(TOK_W)) u_cell (
      .cfg     (cfg[i]),
      .tok_in  (link[i]),
      .wrap_in (rot[i]),
      .tok_out (link[i+1]),
      .rot_out (rot[i])
    );
  end

  assign tok_final = link[N];
endmodule

// File: rtl/tok_tally.sv
module tok_tally #(
  parameter int unsigned N     = 16,
  parameter int unsigned TOK_W = 3
) (
  input  logic [N-1:0]            rot,
  input  logic [TOK_W-1:0]        tok_final,
  output logic [$clog2(N+1)-1:0]  total
);
  localparam int unsigned CW = $clog2(N+1);

  always_comb begin
    int unsigned wraps;
    int unsigned sum;
    wraps = 0;
    for (int unsigned i = 0; i < N; i++) begin
      wraps = wraps + int'(rot[i]);
    end
    sum   = wraps * TOK_W
          + ones_chain_pkg::hot_index(32'(tok_final), TOK_W);
    total = CW'(sum);
  end
endmodule

// File: rtl/ones_chain_counter.sv
module ones_chain_counter #(
  parameter int unsigned N     = ones_chain_pkg::DEF_CELLS,
  parameter int unsigned TOK_W = ones_chain_pkg::DEF_TOKEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N-1:0]             in_vec,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(N+1)-1:0]   count
);
  localparam int unsigned CW = $clog2(N+1);

  logic [TOK_W-1:0] tok_final;
  logic [N-1:0]     rot;
  logic [CW-1:0]    total;
  logic             take;

  ss_chain #(.N(N), .TOK_W(TOK_W)) u_chain (
    .cfg       (in_vec),
    .tok_final (tok_final),
    .rot       (rot)
  );

  tok_tally #(.N(N), .TOK_W(TOK_W)) u_tally (
    .rot       (rot),
    .tok_final (tok_final),
    .total     (total)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      count     <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        count     <= total;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ones_chain_counter_chk.sv
module ones_chain_counter_chk #(
  parameter int unsigned N     = 16,
  parameter int unsigned TOK_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [N-1:0]            in_vec,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [$clog2(N+1)-1:0]  count
);
  localparam int unsigned CW = $clog2(N+1);

  a_r2_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> count == CW'($countones($past(in_vec))));

  a_r3_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(count));

  a_r6_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> count <= CW'(N));

  // TOK_W is used only to keep the parameter set aligned with the top
  initial begin
    a_r8_token_width: assert (TOK_W >= 2);
  end
endmodule

bind ones_chain_counter ones_chain_counter_chk #(.N(N), .TOK_W(TOK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .count     (count)
);

// File: tb/ones_chain_counter_bench.sv
module ones_chain_counter_bench;
  localparam int unsigned N  = 16;
  localparam int unsigned CW = $clog2(N+1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_vec = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [CW-1:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  ones_chain_counter #(.N(N), .TOK_W(3)) u_ones_chain_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .count     (count)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 count", int'(count), 0);
    check("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R7 full word, consumer stalled
    in_vec = '1; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), 1);
    check("R7 all ones", int'(count), N);
    check("R3 in_ready low", int'(in_ready), 0);

    // R4 offered words ignored while stalled
    in_vec = 16'h0001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 count held", int'(count), N);
      check("R3 valid held", int'(out_valid), 1);
    end

    // R6 drain without new word
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R6 out_valid low", int'(out_valid), 0);
    check("R6 count kept", int'(count), N);

    // R7 all zeros
    in_vec = '0; in_valid = 1'b1;
    @(negedge clk);
    check("R7 zero valid", int'(out_valid), 1);
    check("R7 zero count", int'(count), 0);

    // R5/R8 exhaustive streaming, consume and load every edge
    prev = '0;
    for (int v = 0; v < (1 << N); v++) begin
      in_vec = N'(v);
      @(negedge clk);
      if (v > 0 || 1) begin
        check("R5 valid stays", int'(out_valid), 1);
        check("R8 popcount", int'(count), $countones(N'(v)));
      end
      prev = N'(v);
    end

    // R6 stream ends
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 drained", int'(out_valid), 0);
    check("R6 last count", int'(count), $countones(prev));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule